// File: doc/BRIEF.md
# Paged serial-bus memory target

This block is an I2C target that sits in front of two small byte-addressed memory regions and a single 8-bit configuration register. The system clock samples SCL and SDA. The block drives SDA open-drain through an active-high pull-down enable. The first byte after START selects the target. A 4-bit type code in bits [7:4] chooses the standard region, the alternate region or the configuration register. Two select bits in [3:2] must equal the strap inputs. Bit 0 is the read/write flag.

A write has three parts: the address byte, a word-address byte and then data bytes. The data bytes collect in a page buffer whose index wraps inside the current page. The buffered bytes are copied into the region only when the transfer ends with STOP. The target then stays busy for a fixed number of clocks and ignores the bus. A read places a word address with an address-only write, then issues a repeated START and a read-type address byte. The target returns bytes from successive addresses for as long as the controller acknowledges each one.

The state machine has these states: `ST_IDLE`, `ST_DEVADDR`, `ST_DEVACK`, `ST_WORDADDR`, `ST_WORDACK`, `ST_WRDATA`, `ST_WRACK`, `ST_RDDATA`, `ST_RDACK` and `ST_BUSY`. A START moves any state except `ST_BUSY` to `ST_DEVADDR`. A STOP moves any state except `ST_BUSY` to `ST_BUSY` if data is pending, and to `ST_IDLE` otherwise. The other transitions happen on SCL falling edges:
- `ST_DEVADDR` goes to `ST_DEVACK` on a match and to `ST_IDLE` on a miss.
- `ST_DEVACK` goes to `ST_WORDADDR` for a write and to `ST_RDDATA` for a read.
- `ST_WORDADDR` goes to `ST_WORDACK`, and `ST_WORDACK` goes to `ST_WRDATA`.
- `ST_WRDATA` and `ST_WRACK` alternate, one pair per data byte.
- `ST_RDDATA` goes to `ST_RDACK`.
- `ST_RDACK` returns to `ST_RDDATA` after an ACK and goes to `ST_IDLE` after a NACK.
- `ST_BUSY` goes to `ST_IDLE` when its counter expires.

Top module: `serial_mem_slave`

## Requirements
- R1: The target acknowledges an address byte only if bits [7:4] are 1010 (standard region), 1011 (alternate region) or 1001 (configuration register) and bits [3:2] equal `strap_sel`. Bit 1 has no effect. Any other byte gets no ACK and the target waits for the next START.
- R2: In a write, the byte after the address byte is acknowledged. Its low log2(MEM_DEPTH) bits become the current word address.
- R3: Every data byte of a write is acknowledged and stored at the current address. After each byte, only the low log2(PAGE_BYTES) address bits increment, wrapping inside the page. A byte beyond PAGE_BYTES overwrites the earliest bytes of the same page.
- R4: Buffered data reaches the region only when STOP ends the write. A repeated START before STOP discards the buffered bytes.
- R5: After a STOP that commits data, the target ignores the bus for WRITE_CYCLES clocks (at least PAGE_BYTES). During that time it acknowledges no address and never drives SDA.
- R6: A read returns bytes MSB first, starting at the current word address. After each byte the address increments across the whole region and wraps at MEM_DEPTH, for as long as the controller ACKs.
- R7: After the controller NACKs a read byte, the target releases SDA and returns to idle.
- R8: The standard and alternate regions are separate storage. A write to one never changes the other.
- R9: A write addressed with type 1001 commits its last data byte to the configuration register at STOP. A read with type 1001 returns that register.
- R10: After reset, SDA is released and every memory byte and the configuration register read as zero.
- R11: START and STOP are recognised as SDA falling or rising while SCL is high. A START restarts address reception from any state except busy. The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| strap_sel | input | 2 | Select bits that the address byte must match |
| sda_oe | output | 1 | Pulls SDA low when high |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except to make a START or a STOP. They also assume that each SCL level lasts several clock cycles, so the synchronised edges stay ordered. The same assumption covers the check that the SDA drive changes only while SCL is low. The bench generates the bus with quarter-bit phases of five clocks and moves SDA only in the low phase. It never issues a START or STOP while the target is driving a data bit. It therefore ends every read with a NACK before the STOP.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_WORDADDR,
        ST_WORDACK,
        ST_WRDATA,
        ST_WRACK,
        ST_RDDATA,
        ST_RDACK,
        ST_BUSY
    } st_e;

    typedef enum logic [1:0] {
        RG_STD = 2'd0,
        RG_ALT = 2'd1,
        RG_CFG = 2'd2
    } region_e;

    localparam logic [3:0] CODE_STD = 4'b1010;
    localparam logic [3:0] CODE_ALT = 4'b1011;
    localparam logic [3:0] CODE_CFG = 4'b1001;

endpackage

// File: rtl/smem_bus_cond.sv
module smem_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = 3;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    always_comb begin
        scl_s     = scl_p[DEPTH-2];
        sda_s     = sda_p[DEPTH-2];
        scl_rise  = scl_p[DEPTH-2] & ~scl_p[DEPTH-1];
        scl_fall  = ~scl_p[DEPTH-2] & scl_p[DEPTH-1];
        start_det = scl_p[DEPTH-2] & scl_p[DEPTH-1] & ~sda_p[DEPTH-2] & sda_p[DEPTH-1];
        stop_det  = scl_p[DEPTH-2] & scl_p[DEPTH-1] & sda_p[DEPTH-2] & ~sda_p[DEPTH-1];
    end

endmodule

// File: rtl/smem_store.sv
module smem_store
    import smem_pkg::*;
#(
    parameter int MEM_DEPTH = 32,
    parameter int AW        = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  region_e       rd_region,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          wr_en,
    input  region_e       wr_region,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata
);
    localparam int NREG = 2;

    logic [NREG*8-1:0] bank_rd;
    logic [7:0]        cfg_q;

    for (genvar g = 0; g < NREG; g++) begin : g_bank
        logic [7:0] cells [MEM_DEPTH];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < MEM_DEPTH; i++) cells[i] <= '0;
            end else if (wr_en && wr_region == region_e'(g)) begin
                cells[wr_addr] <= wr_data;
            end
        end
        assign bank_rd[g*8 +: 8] = cells[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    always_comb begin
        if (rd_region == RG_CFG) rd_data = cfg_q;
        else                     rd_data = bank_rd[int'(rd_region)*8 +: 8];
    end

    // R8
    wr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_region != RG_CFG);

    // R9
    cfg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> !wr_en);

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import smem_pkg::*;
#(
    parameter int MEM_DEPTH    = 32,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_sel,
    output logic       sda_oe
);
    localparam int AW       = $clog2(MEM_DEPTH);
    localparam int PW       = $clog2(PAGE_BYTES);
    localparam int BUSY_LEN = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
    localparam int BW       = $clog2(BUSY_LEN + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smem_bus_cond u_cond (
        .clk, .rst_n, .scl_i, .sda_i,
        .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
    );

    st_e             state;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg, tx, cfg_shadow;
    logic            rw, master_ack, cfg_pend;
    region_e         region, type_region;
    logic [AW-1:0]   addr;
    logic [7:0]      pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [BW-1:0]   busy_cnt;
    logic            addr_hit;
    logic [7:0]      rd_data;
    logic            commit_en, cfg_we;
    logic [PW-1:0]   commit_idx;

    always_comb begin
        addr_hit    = (shreg[3:2] == strap_sel);
        type_region = RG_STD;
        case (shreg[7:4])
            CODE_STD: type_region = RG_STD;
            CODE_ALT: type_region = RG_ALT;
            CODE_CFG: type_region = RG_CFG;
            default:  addr_hit    = 1'b0;
        endcase
    end

    always_comb begin
        commit_idx = busy_cnt[PW-1:0];
        commit_en  = (state == ST_BUSY) && (busy_cnt < BW'(PAGE_BYTES)) && pmask[commit_idx];
        cfg_we     = (state == ST_BUSY) && (busy_cnt == '0) && cfg_pend;
    end

    smem_store #(.MEM_DEPTH(MEM_DEPTH), .AW(AW)) u_store (
        .clk, .rst_n,
        .rd_region (region),
        .rd_addr   (addr),
        .rd_data   (rd_data),
        .wr_en     (commit_en),
        .wr_region (region),
        .wr_addr   ({addr[AW-1:PW], commit_idx}),
        .wr_data   (pbuf[commit_idx]),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_shadow)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            tx         <= '0;
            cfg_shadow <= '0;
            rw         <= 1'b0;
            master_ack <= 1'b0;
            cfg_pend   <= 1'b0;
            region     <= RG_STD;
            addr       <= '0;
            pmask      <= '0;
            busy_cnt   <= '0;
        end else if (state == ST_BUSY) begin
            if (busy_cnt == BW'(BUSY_LEN - 1)) begin
                state    <= ST_IDLE;
                busy_cnt <= '0;
                pmask    <= '0;
                cfg_pend <= 1'b0;
            end else begin
                busy_cnt <= busy_cnt + 1'b1;
            end
        end else if (start_det) begin
            state    <= ST_DEVADDR;
            bitcnt   <= '0;
            pmask    <= '0;
            cfg_pend <= 1'b0;
        end else if (stop_det) begin
            busy_cnt <= '0;
            state    <= (|pmask || cfg_pend) ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (state)
                ST_DEVADDR, ST_WORDADDR, ST_WRDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (state == ST_DEVADDR) begin
                            if (addr_hit) begin
                                state  <= ST_DEVACK;
                                rw     <= shreg[0];
                                region <= type_region;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WORDADDR) begin
                            addr  <= shreg[AW-1:0];
                            state <= ST_WORDACK;
                        end else begin
                            if (region == RG_CFG) begin
                                cfg_shadow <= shreg;
                                cfg_pend   <= 1'b1;
                            end else begin
                                pbuf[addr[PW-1:0]]  <= shreg;
                                pmask[addr[PW-1:0]] <= 1'b1;
                            end
                            addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
                            state        <= ST_WRACK;
                        end
                    end
                end
                ST_DEVACK: if (scl_fall) begin
                    if (rw) begin
                        state <= ST_RDDATA;
                        tx    <= rd_data;
                    end else begin
                        state <= ST_WORDADDR;
                    end
                end
                ST_WORDACK, ST_WRACK: if (scl_fall) state <= ST_WRDATA;
                ST_RDDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            addr   <= addr + 1'b1;
                            state  <= ST_RDACK;
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            state <= ST_RDDATA;
                            tx    <= rd_data;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_IDLE, ST_BUSY: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_DEVACK, ST_WORDACK, ST_WRACK: sda_oe = 1'b1;
            ST_RDDATA:                       sda_oe = ~tx[7];
            default:                         sda_oe = 1'b0;
        endcase
    end

    // R11
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R3
    page_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WRDATA && state == ST_WRACK) |->
            (addr[PW-1:0] == PW'($past(addr[PW-1:0]) + 1'b1)) &&
            (addr[AW-1:PW] == $past(addr[AW-1:PW])));

    // R4
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BUSY) |-> $past(stop_det));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BUSY |-> busy_cnt < BW'(BUSY_LEN));

endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
    localparam int DEPTH = 32;
    localparam int PAGE  = 16;
    localparam int WCYC  = 600;
    localparam int Q     = 5;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    serial_mem_slave #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) uut (
        .clk, .rst_n, .scl_i(m_scl), .sda_i(sda_line), .strap_sel(STRAP), .sda_oe
    );

    int errs = 0;
    int checks = 0;
    logic [7:0] ma [DEPTH];
    logic [7:0] mb [DEPTH];
    logic [7:0] cfg_m = 8'h00;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] model(logic [3:0] t, int a);
        if (t == 4'b1001)      return cfg_m;
        else if (t == 4'b1010) return ma[a % DEPTH];
        else                   return mb[a % DEPTH];
    endfunction

    function automatic logic [7:0] dev(logic [3:0] t, logic rd);
        return {t, STRAP, 1'b0, rd};
    endfunction

    // Address-only write, repeated START, sequential read of n bytes, NACK, STOP
    task automatic read_check(logic [3:0] t, logic [7:0] a, int n, string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(dev(t, 1'b0), ack); chk("R1", ack, 1'b1);
        send_byte(a, ack);            chk("R2", ack, 1'b1);
        bus_start();
        send_byte(dev(t, 1'b1), ack); chk("R11", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(req, b, model(t, int'(a % DEPTH) + i));
        end
        chk("R7", sda_oe, 1'b0);
        bus_stop();
        chk("R7", sda_oe, 1'b0);
    endtask

    task automatic write_seq(logic [3:0] t, logic [7:0] a, int n, logic [7:0] base, string req);
        logic ack;
        bus_start();
        send_byte(dev(t, 1'b0), ack); chk("R1", ack, 1'b1);
        send_byte(a, ack);            chk("R2", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), ack);
            chk(req, ack, 1'b1);
        end
    endtask

    initial begin
        tick(190000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic ack;
        for (int i = 0; i < DEPTH; i++) begin
            ma[i] = '0;
            mb[i] = '0;
        end
        tick(5);
        // R10: SDA released during reset
        chk("R10", sda_oe, 1'b0);
        rst_n = 1'b1;
        tick(5);
        chk("R10", sda_oe, 1'b0);

        // R1: sweep every type code, select value and bit 1
        for (int t = 0; t < 16; t++) begin
            for (int s = 0; s < 4; s++) begin
                for (int b1 = 0; b1 < 2; b1++) begin
                    logic exp;
                    exp = (t == 10 || t == 11 || t == 9) && (s == int'(STRAP));
                    bus_start();
                    send_byte({4'(t), 2'(s), 1'(b1), 1'b0}, ack);
                    chk("R1", ack, exp);
                    bus_stop();
                end
            end
        end

        // R10: untouched memory reads zero in both regions and config
        read_check(4'b1010, 8'h00, 2, "R10");
        read_check(4'b1011, 8'h1F, 1, "R10");
        read_check(4'b1001, 8'h00, 1, "R10");

        // R3: 20-byte page write starting at 3, wraps inside page 0
        write_seq(4'b1010, 8'h03, 20, 8'h10, "R3");
        bus_stop();
        for (int i = 0; i < 20; i++) ma[(3 + i) % PAGE] = 8'h10 + 8'(i);
        // R5: immediately after committing STOP, target is deaf
        bus_start();
        send_byte(dev(4'b1010, 1'b0), ack);
        chk("R5", ack, 1'b0);
        chk("R5", sda_oe, 1'b0);
        bus_stop();
        tick(WCYC + 50);

        // R6: sequential read of the whole region, then wrap at region end
        read_check(4'b1010, 8'h00, 32, "R6");
        read_check(4'b1010, 8'h1E, 4, "R6");
        // R2: upper bits of the word-address byte beyond the region are dropped
        read_check(4'b1010, 8'h23, 1, "R2");

        // R8: writes to the alternate region leave the standard one alone
        write_seq(4'b1011, 8'h14, 3, 8'h77, "R3");
        bus_stop();
        for (int i = 0; i < 3; i++) mb[20 + i] = 8'h77 + 8'(i);
        tick(WCYC + 50);
        read_check(4'b1011, 8'h10, 16, "R8");
        read_check(4'b1010, 8'h10, 16, "R8");
        read_check(4'b1011, 8'h03, 1, "R8");

        // R4: data followed by a repeated START is discarded
        write_seq(4'b1010, 8'h00, 2, 8'hEE, "R3");
        read_check(4'b1010, 8'h00, 4, "R4");
        read_check(4'b1010, 8'h00, 2, "R4");

        // R9: configuration register keeps the last byte written
        write_seq(4'b1001, 8'h00, 2, 8'h5A, "R9");
        bus_stop();
        cfg_m = 8'h5B;
        tick(WCYC + 50);
        read_check(4'b1001, 8'h00, 1, "R9");
        read_check(4'b1010, 8'h00, 1, "R9");

        finish_run();
    end

endmodule